// File: doc/BRIEF.md
# Fault Status Register Bank

This block holds the fault status and fault address registers of a microcontroller interrupt controller, on a 32-bit register bus. The core sends it single-cycle events: an undefined instruction, a data access violation with the faulting address, and the escalation of a configurable fault to a hard fault. Each event sets sticky flags. Software reads the flags and clears them by writing ones. A violation also captures its address in a fault address register.

Two status registers hold the flags. Two address registers hold a captured or software-loaded address. Two reserved locations in the same window read as zero and ignore writes. Read data is registered. No event in this block raises a bus fault, so the bus fault address register changes only when software writes it.

Top module: `fault_status_bank`

## Requirements
- R1: After the synchronous active-low reset, every register reads as zero.
- R2: An undefined-instruction event sets bit 16 of the configurable status register (byte offset 0xD28).
- R3: A data access violation event sets bits 1 and 7 of the configurable status register and loads the event address into the memory fault address register (offset 0xD34).
- R4: An escalation event sets bit 30 of the hard fault status register (offset 0xD2C).
- R5: A write to either status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: When a hardware event sets a status bit in the same cycle that a write clears it, the bit ends up set. When a violation and a software write to the memory fault address register fall in the same cycle, the violation address is stored.
- R7: Events OR their bits into the status registers and leave the other bits unchanged. A new violation overwrites the previously captured address.
- R8: A write to the memory fault address register or to the bus fault address register (offset 0xD38) stores the write data, and that register then reads it back. The bus fault address register changes only through such writes.
- R9: Offsets 0xD30 and 0xD3C, and every offset that is not decoded, read as zero, and writes to them leave every register unchanged. Decoding uses address bits [11:2] only.
- R10: Read data is captured on the clock edge at which the read strobe is high, and reflects register state from before any write in that same cycle. Read data holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ev_undef | input | 1 | Undefined-instruction event |
| ev_viol | input | 1 | Data access violation event |
| ev_addr | input | 32 | Faulting address for a violation |
| ev_escalate | input | 1 | Escalation-to-hard-fault event |

## Verification
A wrong internal state shows up on the first read of the affected register, one cycle after the read strobe. If a flag is lost or a clear is skipped, the status word read back has a wrong bit. If the decode is wrong, a write to one location changes a neighbouring register, and the next read-back of all four registers shows the change. The bench sweeps writes across a window of word offsets and reads back every register after each write, so a decode or priority error is reported within a few cycles of the access that caused it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int DATA_W = 32;

  localparam logic [11:0] OFS_CFG_STAT  = 12'hD28;
  localparam logic [11:0] OFS_HARD_STAT = 12'hD2C;
  localparam logic [11:0] OFS_RSVD_DBG  = 12'hD30;
  localparam logic [11:0] OFS_MEM_ADDR  = 12'hD34;
  localparam logic [11:0] OFS_BUS_ADDR  = 12'hD38;
  localparam logic [11:0] OFS_RSVD_AUX  = 12'hD3C;

  localparam int BIT_UNDEF  = 16;
  localparam int BIT_DVIOL  = 1;
  localparam int BIT_MVALID = 7;
  localparam int BIT_FORCED = 30;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_HARD,
    SEL_MEMA,
    SEL_BUSA,
    SEL_RSVD
  } reg_sel_e;

  // Write-one-to-clear update in which a set wins over a clear.
  function automatic logic [DATA_W-1:0] w1c_next(
    input logic [DATA_W-1:0] cur,
    input logic              clr_en,
    input logic [DATA_W-1:0] clr_mask,
    input logic [DATA_W-1:0] set_mask
  );
    logic [DATA_W-1:0] kill;
    kill = clr_en ? clr_mask : '0;
    return (cur & ~kill) | set_mask;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_set_mask(input logic undef, input logic viol);
    logic [DATA_W-1:0] m;
    m = '0;
    m[BIT_UNDEF]  = undef;
    m[BIT_DVIOL]  = viol;
    m[BIT_MVALID] = viol;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] hard_set_mask(input logic esc);
    logic [DATA_W-1:0] m;
    m = '0;
    m[BIT_FORCED] = esc;
    return m;
  endfunction
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic              wr_cfg,
  output logic              wr_hard,
  output logic              wr_mema,
  output logic              wr_busa
);
  localparam int WORD_LSB = 2;

  function automatic logic word_hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    logic [ADDR_W-1:0] full;
    full = ADDR_W'(ofs);
    return a[ADDR_W-1:WORD_LSB] == full[ADDR_W-1:WORD_LSB];
  endfunction

  always_comb begin
    sel = SEL_NONE;
    if (word_hit(addr, OFS_CFG_STAT))       sel = SEL_CFG;
    else if (word_hit(addr, OFS_HARD_STAT)) sel = SEL_HARD;
    else if (word_hit(addr, OFS_MEM_ADDR))  sel = SEL_MEMA;
    else if (word_hit(addr, OFS_BUS_ADDR))  sel = SEL_BUSA;
    else if (word_hit(addr, OFS_RSVD_DBG) || word_hit(addr, OFS_RSVD_AUX)) sel = SEL_RSVD;
  end

  assign wr_cfg  = wr && (sel == SEL_CFG);
  assign wr_hard = wr && (sel == SEL_HARD);
  assign wr_mema = wr && (sel == SEL_MEMA);
  assign wr_busa = wr && (sel == SEL_BUSA);
endmodule

// File: rtl/fsr_sticky_reg.sv
module fsr_sticky_reg
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [DATA_W-1:0] set_mask,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= w1c_next(q, clr_en, clr_mask, set_mask);
  end
endmodule

// File: rtl/fsr_addr_reg.sv
module fsr_addr_reg
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_ld,
  input  logic [DATA_W-1:0] hw_val,
  input  logic              sw_ld,
  input  logic [DATA_W-1:0] sw_val,
  output logic [DATA_W-1:0] q
);
  // A hardware capture takes priority over a software load.
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (hw_ld) q <= hw_val;
    else if (sw_ld) q <= sw_val;
  end
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              ev_undef,
  input  logic              ev_viol,
  input  logic [31:0]       ev_addr,
  input  logic              ev_escalate
);
  reg_sel_e          sel;
  logic              wr_cfg, wr_hard, wr_mema, wr_busa;
  logic [DATA_W-1:0] cfg_set, hard_set;
  logic [DATA_W-1:0] cfg_q, hard_q, mema_q, busa_q;
  logic [DATA_W-1:0] rd_mux;

  fsr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .sel(sel),
    .wr_cfg(wr_cfg), .wr_hard(wr_hard), .wr_mema(wr_mema), .wr_busa(wr_busa)
  );

  assign cfg_set  = cfg_set_mask(ev_undef, ev_viol);
  assign hard_set = hard_set_mask(ev_escalate);

  fsr_sticky_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .clr_en(wr_cfg), .clr_mask(bus_wdata),
    .set_mask(cfg_set), .q(cfg_q)
  );

  fsr_sticky_reg u_hard (
    .clk(clk), .rst_n(rst_n), .clr_en(wr_hard), .clr_mask(bus_wdata),
    .set_mask(hard_set), .q(hard_q)
  );

  fsr_addr_reg u_mema (
    .clk(clk), .rst_n(rst_n), .hw_ld(ev_viol), .hw_val(ev_addr),
    .sw_ld(wr_mema), .sw_val(bus_wdata), .q(mema_q)
  );

  fsr_addr_reg u_busa (
    .clk(clk), .rst_n(rst_n), .hw_ld(1'b0), .hw_val('0),
    .sw_ld(wr_busa), .sw_val(bus_wdata), .q(busa_q)
  );

  always_comb begin
    unique case (sel)
      SEL_CFG:  rd_mux = cfg_q;
      SEL_HARD: rd_mux = hard_q;
      SEL_MEMA: rd_mux = mema_q;
      SEL_BUSA: rd_mux = busa_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // Event flags
  assert_undef_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_undef |=> cfg_q[BIT_UNDEF]);
  assert_viol_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_viol |=> (cfg_q[BIT_DVIOL] && cfg_q[BIT_MVALID]));
  assert_viol_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_viol |=> (mema_q == $past(ev_addr)));
  assert_escalate_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_escalate |=> hard_q[BIT_FORCED]);

  // Clears without a competing set
  assert_cfg_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !ev_undef && !ev_viol) |=> ((cfg_q & $past(bus_wdata)) == '0));
  assert_hard_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hard && !ev_escalate) |=> ((hard_q & $past(bus_wdata)) == '0));

  // Bus fault address register is software-only
  assert_busa_sw_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_busa |=> $stable(busa_q));

  // Reserved and unmapped writes reach no register
  assert_rsvd_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RSVD || sel == SEL_NONE) |-> !(wr_cfg || wr_hard || wr_mema || wr_busa));

  // Read data holds between strobes
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_fault_status_bank.sv
module sim_fault_status_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        ev_undef = 1'b0;
  logic        ev_viol = 1'b0;
  logic [31:0] ev_addr = '0;
  logic        ev_escalate = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_cfg = '0, m_hard = '0, m_mema = '0, m_busa = '0;

  always #4 clk = ~clk;

  fault_status_bank #(.ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ev_undef(ev_undef), .ev_viol(ev_viol), .ev_addr(ev_addr),
    .ev_escalate(ev_escalate)
  );

  function automatic logic [31:0] ref_read(input logic [11:0] a);
    case ({a[11:2], 2'b00})
      12'hD28: return m_cfg;
      12'hD2C: return m_hard;
      12'hD34: return m_mema;
      12'hD38: return m_busa;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // One bus/event cycle: drive after a falling edge, apply at the rising edge.
  task automatic cycle(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic rd, input logic und, input logic vio,
                       input logic [31:0] va, input logic esc,
                       input logic do_chk, input string req);
    logic [31:0] exp_rd;
    logic [11:0] wa;
    exp_rd = ref_read(a);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd;
    ev_undef = und; ev_viol = vio; ev_addr = va; ev_escalate = esc;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; ev_undef = 1'b0; ev_viol = 1'b0; ev_escalate = 1'b0;
    wa = {a[11:2], 2'b00};
    if (wr && wa == 12'hD28) m_cfg  = m_cfg & ~d;
    if (wr && wa == 12'hD2C) m_hard = m_hard & ~d;
    if (wr && wa == 12'hD34) m_mema = d;
    if (wr && wa == 12'hD38) m_busa = d;
    if (und) m_cfg[16] = 1'b1;
    if (vio) begin m_cfg[1] = 1'b1; m_cfg[7] = 1'b1; m_mema = va; end
    if (esc) m_hard[30] = 1'b1;
    if (do_chk) check(bus_rdata, exp_rd, req);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "");
  endtask

  task automatic rd_chk(input logic [11:0] a, input string req);
    cycle(1'b0, a, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, req);
  endtask

  task automatic event_only(input logic und, input logic vio, input logic [31:0] va, input logic esc);
    cycle(1'b0, 12'h0, 32'h0, 1'b0, und, vio, va, esc, 1'b0, "");
  endtask

  task automatic rd_all(input string req);
    rd_chk(12'hD28, req);
    rd_chk(12'hD2C, req);
    rd_chk(12'hD34, req);
    rd_chk(12'hD38, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(bus_rdata, 32'h0, "R1 rdata after reset");
    rd_all("R1 reset value");
    rd_chk(12'hD30, "R1 reserved after reset");

    // R2 undefined instruction
    event_only(1'b1, 1'b0, 32'h0, 1'b0);
    rd_chk(12'hD28, "R2 undef bit16");
    check(ref_read(12'hD28), 32'h0001_0000, "R2 reference sanity");

    // R3 violation capture
    event_only(1'b0, 1'b1, 32'h2000_1234, 1'b0);
    rd_chk(12'hD28, "R3 R7 viol bits 1 and 7 ORed with bit16");
    rd_chk(12'hD34, "R3 captured address");

    // R4 escalation
    event_only(1'b0, 1'b0, 32'h0, 1'b1);
    rd_chk(12'hD2C, "R4 forced bit30");

    // R7 new violation overwrites address
    event_only(1'b0, 1'b1, 32'hDEAD_BEE0, 1'b0);
    rd_chk(12'hD34, "R7 address overwrite");
    rd_chk(12'hD28, "R7 flags preserved");

    // R5 W1C: zero bits keep, one bits clear
    wr_reg(12'hD28, 32'h0000_0002);
    rd_chk(12'hD28, "R5 partial clear");
    wr_reg(12'hD28, 32'h0000_0000);
    rd_chk(12'hD28, "R5 zero write keeps");
    wr_reg(12'hD2C, 32'hFFFF_FFFF);
    rd_chk(12'hD2C, "R5 hard clear");

    // R6 set wins over clear in the same cycle
    cycle(1'b1, 12'hD28, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, "");
    rd_chk(12'hD28, "R6 undef set beats clear");
    check(bus_rdata, 32'h0001_0000, "R6 only bit16 remains");
    cycle(1'b1, 12'hD2C, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, "");
    rd_chk(12'hD2C, "R6 forced set beats clear");
    cycle(1'b1, 12'hD34, 32'h1111_1111, 1'b0, 1'b0, 1'b1, 32'h5555_0004, 1'b0, 1'b0, "");
    rd_chk(12'hD34, "R6 violation beats address write");
    check(bus_rdata, 32'h5555_0004, "R6 captured value");

    // R8 address registers load from software
    wr_reg(12'hD38, 32'hCAFE_F00D);
    rd_chk(12'hD38, "R8 bus address write");
    wr_reg(12'hD34, 32'h0BAD_CAFE);
    rd_chk(12'hD34, "R8 mem address write");
    event_only(1'b1, 1'b1, 32'h7777_0000, 1'b1);
    rd_chk(12'hD38, "R8 bus address untouched by events");

    // R9 reserved and unmapped locations
    wr_reg(12'hD30, 32'hFFFF_FFFF);
    wr_reg(12'hD3C, 32'hFFFF_FFFF);
    rd_chk(12'hD30, "R9 debug reserved reads zero");
    rd_chk(12'hD3C, "R9 aux reserved reads zero");
    rd_all("R9 reserved writes ignored");
    rd_chk(12'hD2B, "R9 low bits ignored in decode");

    // R10 same-cycle read and write returns old value; hold without strobe
    hold = m_busa;
    cycle(1'b1, 12'hD38, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, "R10 read before write");
    check(bus_rdata, hold, "R10 old value returned");
    event_only(1'b1, 1'b1, 32'h9999_0000, 1'b1);
    wr_reg(12'hD38, 32'h0);
    check(bus_rdata, hold, "R10 rdata holds without strobe");

    // R9 R8 R5 sweep of writes over 64 word offsets from 0xD00
    for (int w = 0; w < 64; w++) begin
      logic [11:0] a;
      a = 12'hD00 + 12'(w * 4);
      event_only(1'b1, 1'b1, 32'hA000_0000 | 32'(w), 1'b1);
      wr_reg(a, 32'hFFFF_0000 ^ (32'(w) * 32'h0101_0101));
      rd_chk(a, "R9 sweep read of written offset");
      rd_all("R5 R8 R9 sweep neighbours");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule